// File: doc/BRIEF.md
# Aligned PWM Timer Channel

A single pulse-width channel with its own time base. A power-of-two prescaler divides the clock into count ticks. A 16-bit counter steps on each tick against a period register. In edge mode it counts upward only and then wraps. In center mode it climbs to the period and falls back to zero. Two outputs, a high-side one and a low-side one, each compare the counter with their own compare value. Each output has its own enable and its own polarity control, so inverting only the low output with equal compare values gives a complementary pair.

Software configures the channel through a small write port with five addresses. Three level inputs gate the channel: a shared clock enable that stops every timer and output, a timer enable, and an output enable. While the timer runs, compare values pass through shadow registers and become active only at the point where the count returns to zero. This keeps a duty change from producing a glitch partway through a period. Writing the counter address restarts the count from any value.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, every register is zero and both outputs are low.
- R2: Control bits [5:2] hold N. A count tick occurs once every 2^N clock cycles, and writing the counter restarts the prescaler phase, so the first tick after that write comes 2^N cycles later.
- R3: Control bits [1:0] = 2'b01 select edge mode. On each tick the counter adds one, and at a count at or above the period it returns to 0. A sequence therefore lasts period+1 ticks, and the high output is active while count < active high compare.
- R4: Control bits [1:0] = 2'b10 select center mode. The counter runs 0 up to the period and then back down to 0, so a sequence lasts 2*period ticks. An output with compare c is active for 2c-1 ticks of each sequence.
- R5: A compare value of 0 keeps its output inactive. A compare value above the period keeps it active.
- R6: The counter holds its value while the mode is 2'b00 or 2'b11, while tmr_en is low, or while clk_en_all is low.
- R7: A write to address 2 loads the counter in the next cycle and takes priority over a tick in the same cycle. Counting continues from the loaded value.
- R8: While the counter runs, writes to address 3 (high compare) and address 4 (low compare) take effect only at the edge-mode wrap or at the center-mode return to zero. While the counter is stopped they take effect at once.
- R9: A compare write that lands on the same edge as a reload takes effect at the following reload. That reload edge makes the previous shadow value active.
- R10: Control bit 6 enables the high output and bit 7 the low output. A disabled output, or any output while pwm_en or clk_en_all is low, is driven low before inversion.
- R11: Control bit 8 inverts the high output and bit 9 inverts the low output. With equal compare values and only the low output inverted, the low output is the exact complement of the high output.
- R12: The low output compares against its own value (address 4). The period is written at address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_all | input | 1 | Shared enable gating all timers and outputs |
| tmr_en | input | 1 | Timer enable for this channel |
| pwm_en | input | 1 | Output enable for this channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2 counter, 3 high compare, 4 low compare |
| wr_data | input | 16 | Register write data |
| out_hi | output | 1 | High-side PWM output |
| out_lo | output | 1 | Low-side PWM output |

## Verification
Two events can fall on the same clock edge: a compare-register write and the reload of the active compare at the wrap. The bench restarts the counter at a known edge and counts the cycles so that the write lands exactly on the wrap edge. It then checks that the output keeps following the older compare for one whole sequence and changes only at the reload after that. A counter write also lands on an edge where a tick would otherwise advance the count. The output level in the next cycle, and in the one after it, shows which of the two took effect.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

    localparam int unsigned DIV_W  = 4;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'b00,
        MODE_EDGE   = 2'b01,
        MODE_CENTER = 2'b10,
        MODE_SPARE  = 2'b11
    } count_mode_e;

    typedef struct packed {
        logic             lo_inv;
        logic             hi_inv;
        logic             lo_en;
        logic             hi_en;
        logic [DIV_W-1:0] div;
        count_mode_e      mode;
    } chan_ctrl_t;

    localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CMP_LO = 3'd4;

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] mask;

    assign mask = ~({PRE_W{1'b1}} << div_sel);
    assign tick = run && (st_q.phase == mask);

    always_comb begin
        st_d = st_q;
        if (restart || !run || tick) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter import pwm_timer_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  count_mode_e      mode,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             reload
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             up;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] dec;

    assign dec = (st_q.value == '0) ? '0 : st_q.value - 1'b1;
    assign cnt = st_q.value;

    always_comb begin
        st_d   = st_q;
        reload = 1'b0;
        if (load) begin
            st_d.value = load_val;
            st_d.up    = 1'b1;
        end else if (tick) begin
            if (mode == MODE_EDGE) begin
                st_d.up = 1'b1;
                if (st_q.value >= period) begin
                    st_d.value = '0;
                    reload     = 1'b1;
                end else begin
                    st_d.value = st_q.value + 1'b1;
                end
            end else if (st_q.up) begin
                if (st_q.value >= period) begin
                    st_d.value = dec;
                    st_d.up    = (dec == '0);
                    reload     = (dec == '0);
                end else begin
                    st_d.value = st_q.value + 1'b1;
                end
            end else begin
                st_d.value = dec;
                if (dec == '0) begin
                    st_d.up = 1'b1;
                    reload  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{value: '0, up: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_outstage.sv
`timescale 1ns/1ps
module pwm_outstage #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             enable,
    input  logic             invert,
    output logic             pwm_o
);
    logic active;

    assign active = enable && (cnt < cmp);
    assign pwm_o  = active ^ invert;
endmodule

// File: rtl/pwm_timer_chan.sv
`timescale 1ns/1ps
module pwm_timer_chan import pwm_timer_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_all,
    input  logic              tmr_en,
    input  logic              pwm_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              out_hi,
    output logic              out_lo
);
    localparam int NUM_OUT = 2;

    typedef struct packed {
        chan_ctrl_t       ctrl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] shd_hi;
        logic [CNT_W-1:0] shd_lo;
        logic [CNT_W-1:0] act_hi;
        logic [CNT_W-1:0] act_lo;
    } chan_regs_t;

    chan_regs_t r_d, r_q;

    logic             run;
    logic             tick;
    logic             reload;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt;

    assign run = clk_en_all && tmr_en &&
                 ((r_q.ctrl.mode == MODE_EDGE) || (r_q.ctrl.mode == MODE_CENTER));
    assign cnt_load = wr_en && (wr_addr == ADDR_COUNT);

    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cnt_load),
        .div_sel (r_q.ctrl.div),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (r_q.ctrl.mode),
        .period   (r_q.period),
        .load     (cnt_load),
        .load_val (wr_data),
        .cnt      (cnt),
        .reload   (reload)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:   r_d.ctrl   = chan_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_PERIOD: r_d.period = wr_data;
                ADDR_CMP_HI: r_d.shd_hi = wr_data;
                ADDR_CMP_LO: r_d.shd_lo = wr_data;
                default:     ;
            endcase
        end
        if (!run) begin
            r_d.act_hi = r_d.shd_hi;
            r_d.act_lo = r_d.shd_lo;
        end else if (reload) begin
            r_d.act_hi = r_q.shd_hi;
            r_d.act_lo = r_q.shd_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic [NUM_OUT-1:0] gate;
    logic [NUM_OUT-1:0] inv;
    logic [NUM_OUT-1:0] pwm_raw;
    logic [CNT_W-1:0]   cmp_sel [NUM_OUT];

    assign gate       = {r_q.ctrl.lo_en, r_q.ctrl.hi_en} & {NUM_OUT{clk_en_all && pwm_en}};
    assign inv        = {r_q.ctrl.lo_inv, r_q.ctrl.hi_inv};
    assign cmp_sel[0] = r_q.act_hi;
    assign cmp_sel[1] = r_q.act_lo;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        pwm_outstage #(.CNT_W(CNT_W)) u_out (
            .cnt    (cnt),
            .cmp    (cmp_sel[i]),
            .enable (gate[i]),
            .invert (inv[i]),
            .pwm_o  (pwm_raw[i])
        );
    end

    assign out_hi = pwm_raw[0];
    assign out_lo = pwm_raw[1];
endmodule

// File: rtl/pwm_timer_chan_chk.sv
`timescale 1ns/1ps
module pwm_timer_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en_all,
    input logic             pwm_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             run,
    input logic             tick,
    input logic             reload,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] act_hi,
    input logic [CNT_W-1:0] act_lo,
    input logic             hi_en,
    input logic             hi_inv,
    input logic             out_hi
);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_load) |=> $stable(cnt));

    p_edge_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load && mode == 2'b01 && cnt >= period) |=> (cnt == '0));

    p_center_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load && mode == 2'b10 && cnt == period && period > 1)
        |=> (cnt == $past(period) - 1'b1));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt == $past(wr_data)));

    p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reload) |=> ($stable(act_hi) && $stable(act_lo)));

    p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_en_all && pwm_en && hi_en) |-> (out_hi == hi_inv));
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_all (clk_en_all),
    .pwm_en     (pwm_en),
    .wr_data    (wr_data),
    .run        (run),
    .tick       (tick),
    .reload     (reload),
    .cnt_load   (cnt_load),
    .cnt        (cnt),
    .period     (r_q.period),
    .mode       (r_q.ctrl.mode),
    .act_hi     (r_q.act_hi),
    .act_lo     (r_q.act_lo),
    .hi_en      (r_q.ctrl.hi_en),
    .hi_inv     (r_q.ctrl.hi_inv),
    .out_hi     (out_hi)
);

// File: tb/pwm_timer_chan_test.sv
`timescale 1ns/1ps
module pwm_timer_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_all = 1'b1;
    logic        tmr_en = 1'b0;
    logic        pwm_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_hi;
    logic        out_lo;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_timer_chan uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_all (clk_en_all),
        .tmr_en     (tmr_en),
        .pwm_en     (pwm_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .out_hi     (out_hi),
        .out_lo     (out_lo)
    );

    // control word: [1:0] mode, [5:2] divider exponent, 6 hi_en, 7 lo_en, 8 hi_inv, 9 lo_inv
    function automatic logic [15:0] mk_ctrl(int mode, int div, bit hen, bit len, bit hinv, bit linv);
        return 16'((mode & 3) | ((div & 15) << 2) | (int'(hen) << 6) | (int'(len) << 7)
                   | (int'(hinv) << 8) | (int'(linv) << 9));
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge, returns at the following negedge
    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int n, output int hi_cnt, output int lo_cnt, output int same_cnt);
        hi_cnt = 0; lo_cnt = 0; same_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi_cnt   += int'(out_hi);
            lo_cnt   += int'(out_lo);
            same_cnt += int'(out_hi == out_lo);
        end
    endtask

    task automatic setup(logic [15:0] ctrl, int per, int chi, int clo);
        tmr_en = 1'b0;
        wr(3'd0, ctrl);
        wr(3'd1, 16'(per));
        wr(3'd3, 16'(chi));
        wr(3'd4, 16'(clo));
        wr(3'd2, 16'd0);
        tmr_en = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 out_hi after reset", int'(out_hi), 0);
        check("R1 out_lo after reset", int'(out_lo), 0);
    endtask

    task automatic t_edge();
        int h, l, s;
        setup(mk_ctrl(1, 0, 1, 1, 0, 0), 9, 3, 7);
        wait_n(3);
        measure(40, h, l, s);
        check("R3 edge hi duty", h, 12);
        check("R12 edge lo own compare", l, 28);
    endtask

    task automatic t_center();
        int h, l, s;
        setup(mk_ctrl(2, 0, 1, 1, 0, 0), 8, 3, 8);
        wait_n(5);
        measure(48, h, l, s);
        check("R4 center hi duty", h, 15);
        check("R4 center lo duty", l, 45);
    endtask

    task automatic t_prescale();
        int h, l, s;
        setup(mk_ctrl(1, 2, 1, 0, 0, 0), 4, 2, 0);
        wait_n(7);
        measure(40, h, l, s);
        check("R2 divided edge duty", h, 16);
        setup(mk_ctrl(1, 2, 1, 0, 0, 0), 9, 1, 0);
        wr(3'd2, 16'd0);
        wait_n(3);
        check("R2 no tick before 4 cycles", int'(out_hi), 1);
        wait_n(1);
        check("R2 tick at 4th cycle", int'(out_hi), 0);
    endtask

    task automatic t_extremes();
        int h, l, s;
        setup(mk_ctrl(1, 0, 1, 1, 0, 0), 9, 0, 12);
        wait_n(2);
        measure(20, h, l, s);
        check("R5 compare zero never active", h, 0);
        check("R5 compare above period always active", l, 20);
    endtask

    task automatic t_stop();
        int h, l, s;
        setup(mk_ctrl(0, 0, 1, 0, 0, 0), 9, 5, 0);
        wr(3'd2, 16'd7);
        measure(30, h, l, s);
        check("R6 hold mode count 7 vs 5", h, 0);
        wr(3'd3, 16'd8);
        measure(30, h, l, s);
        check("R8 stopped compare immediate, R6 held", h, 30);
        setup(mk_ctrl(1, 0, 1, 0, 0, 0), 9, 5, 0);
        tmr_en = 1'b0;
        wr(3'd2, 16'd7);
        wr(3'd3, 16'd8);
        measure(30, h, l, s);
        check("R6 timer disabled holds count", h, 30);
    endtask

    task automatic t_count_write();
        setup(mk_ctrl(1, 0, 1, 0, 0, 0), 9, 6, 0);
        wait_n(4);
        wr(3'd2, 16'd5);
        check("R7 loaded count 5 below 6", int'(out_hi), 1);
        wait_n(1);
        check("R7 count continues to 6", int'(out_hi), 0);
        wait_n(4);
        check("R7 count wrapped to 0", int'(out_hi), 1);
    endtask

    task automatic t_shadow();
        setup(mk_ctrl(1, 0, 1, 0, 0, 0), 9, 3, 0);
        wait_n(2);
        wr(3'd2, 16'd0);
        wait_n(1);
        wr(3'd3, 16'd8);
        wait_n(2);
        check("R8 old compare kept mid period", int'(out_hi), 0);
        wait_n(6);
        check("R8 new compare at wrap", int'(out_hi), 1);
        wait_n(7);
        check("R8 new compare count 7", int'(out_hi), 1);
        wait_n(2);
        wr(3'd3, 16'd2);
        wait_n(5);
        check("R9 write on wrap edge deferred", int'(out_hi), 1);
        wait_n(10);
        check("R9 write active after next wrap", int'(out_hi), 0);
    endtask

    task automatic t_enable();
        int h, l, s;
        setup(mk_ctrl(1, 0, 1, 0, 0, 0), 9, 12, 0);
        pwm_en = 1'b0;
        measure(10, h, l, s);
        check("R10 pwm_en low drives low", h, 0);
        wr(3'd0, mk_ctrl(1, 0, 1, 0, 1, 0));
        measure(10, h, l, s);
        check("R10 disabled then inverted", h, 10);
        pwm_en = 1'b1;
        wr(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0));
        measure(10, h, l, s);
        check("R10 hi_en low drives low", h, 0);
        wr(3'd0, mk_ctrl(1, 0, 1, 0, 0, 0));
        clk_en_all = 1'b0;
        measure(10, h, l, s);
        check("R10 shared enable low drives low", h, 0);
        clk_en_all = 1'b1;
    endtask

    task automatic t_compl();
        int h, l, s;
        setup(mk_ctrl(1, 0, 1, 1, 0, 1), 9, 4, 4);
        wait_n(3);
        measure(40, h, l, s);
        check("R11 hi duty", h, 16);
        check("R11 lo complement duty", l, 24);
        check("R11 cycles with equal outputs", s, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_center();
        t_prescale();
        t_extremes();
        t_stop();
        t_count_write();
        t_shadow();
        t_enable();
        t_compl();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule